// File: doc/BRIEF.md
# Global Compare Timer with Write Confirmation

This block is a system-wide timebase. A 64-bit counter runs upward by one each clock while its run bit is set. Software loads it one 32-bit half at a time and reads it back the same way. Four compare channels watch the counter. When the running counter equals an enabled channel's 64-bit compare value, that channel's pending bit is set, and its interrupt line goes high while the matching enable bit is also set. Channel 0 can re-arm itself to give a periodic tick: on each match it adds a 32-bit increment to its own compare value.

Software learns that a write has landed through sticky confirmation bits. These bits are set a fixed number of cycles after each write to the control, counter, compare or increment registers. Software waits for the bit, then clears it by writing a one to it. All access goes through a single-cycle 32-bit address/data port with a combinational read path.

Top module: `gcmp_timer`

## Requirements
- R1: After reset the counter, control register (0x240), pending register (0x244), both confirmation registers (0x24C, 0x110) and all interrupt outputs read zero.
- R2: While stopped, the counter's low word is written and read at 0x100 and its high word at 0x104.
- R3: While control bit 8 is set, the counter advances by exactly one per clock, with carry from the low word into the high word. While bit 8 is clear, the counter holds its value.
- R4: Channel k has its compare low word at 0x200+0x10*k and its high word at 0x204+0x10*k, and is enabled by control bit 2*k. When the counter is running and equals the compare value of an enabled channel, bit k of 0x244 is set. A disabled channel sets nothing.
- R5: Writing a one to bit k of 0x244 clears that pending bit. Writing a zero leaves it unchanged.
- R6: Output irq[k] is high exactly when pending bit k and enable bit k of 0x248 are both set.
- R7: With control bit 1 set, a channel-0 match replaces compare 0 by compare 0 plus the increment register (0x208), on the same edge that sets pending bit 0. The other channels keep their compare value after a match.
- R8: A confirmation bit becomes readable as one on the second clock edge after the edge that accepts the write, and not before.
- R9: Counter low and high writes confirm in bits 0 and 1 of 0x110 and leave 0x24C untouched.
- R10: In 0x24C, compare k low confirms in bit 4*k, compare k high in bit 4*k+1, the increment in bit 2 and the control register in bit 16.
- R11: Confirmation bits stay set until a one is written to that bit position. Bits written as zero stay set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 4 | One interrupt per compare channel |

## Verification
A wrong counter step shows at 0x100/0x104 on the next read, and it also moves every later match off its expected cycle. A bad auto-add leaves a compare value at 0x200 that differs from the arithmetic sequence 20, 25, 30, 35. That difference is visible as soon as the run stops. A broken confirmation pipeline shows up as a status bit that appears one cycle too early or too late in back-to-back reads just after a write. A wrong clear mask shows in the very next read of 0x24C or 0x244.

// File: rtl/gct_pkg.sv
`timescale 1ns/1ps
package gct_pkg;
    localparam int CNT_W   = 64;
    localparam int HALF_W  = CNT_W / 2;
    localparam int NCMP    = 4;
    localparam int ADDR_W  = 12;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 12'h100;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 12'h104;
    localparam logic [ADDR_W-1:0] A_CSTAT  = 12'h110;
    localparam logic [ADDR_W-1:0] A_INCR   = 12'h208;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h240;
    localparam logic [ADDR_W-1:0] A_PEND   = 12'h244;
    localparam logic [ADDR_W-1:0] A_IEN    = 12'h248;
    localparam logic [ADDR_W-1:0] A_GSTAT  = 12'h24C;

    localparam int RUN_BIT      = 8;
    localparam int AUTO_BIT     = 1;
    localparam int INC_ACK_BIT  = 2;
    localparam int CTRL_ACK_BIT = 16;

    function automatic logic [ADDR_W-1:0] cmp_lo_addr(input int k);
        return 12'h200 + ADDR_W'(k * 16);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_hi_addr(input int k);
        return 12'h204 + ADDR_W'(k * 16);
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              run;
        logic              auto_inc;
        logic [NCMP-1:0]   cmp_en;
        logic [HALF_W-1:0] incr;
        logic [NCMP-1:0]   pend;
        logic [NCMP-1:0]   ien;
    } tmr_state_t;
endpackage

// File: rtl/gct_cmp_chan.sv
`timescale 1ns/1ps
module gct_cmp_chan #(
    parameter int CW = 64,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          run_i,
    input  logic          en_i,
    input  logic          auto_i,
    input  logic [IW-1:0] incr_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [CW/2-1:0] wdata_i,
    output logic [CW-1:0] cmp_o,
    output logic          hit_o
);
    localparam int HW = CW / 2;

    logic [CW-1:0] cmp_d, cmp_q;

    assign hit_o = run_i && en_i && (cnt_i == cmp_q);
    assign cmp_o = cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (hit_o && auto_i) cmp_d = cmp_q + CW'(incr_i);
        if (wr_lo_i) cmp_d[HW-1:0]  = wdata_i;
        if (wr_hi_i) cmp_d[CW-1:HW] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end
endmodule

// File: rtl/gct_wack.sv
`timescale 1ns/1ps
module gct_wack #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] pipe_d [DEPTH];
    logic [W-1:0] pipe_q [DEPTH];
    logic [W-1:0] stat_d, stat_q;

    always_comb begin
        pipe_d[0] = req_i;
        for (int i = 1; i < DEPTH; i++) pipe_d[i] = pipe_q[i-1];
        stat_d = (stat_q & ~clr_i) | pipe_q[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
            stat_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= pipe_d[i];
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/gcmp_timer.sv
`timescale 1ns/1ps
module gcmp_timer
    import gct_pkg::*;
#(
    parameter int ACK_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic [NCMP-1:0]   irq
);
    tmr_state_t s_d, s_q;

    logic cnt_wr_lo, cnt_wr_hi, ctrl_wr, incr_wr, pend_wr, ien_wr, gstat_wr, cstat_wr;
    logic [NCMP-1:0] cmp_wr_lo, cmp_wr_hi, hit_w;
    logic [CNT_W-1:0] cmp_w [NCMP];
    logic [HALF_W-1:0] gack, gstat;
    logic [1:0] cack, cstat;

    assign cnt_wr_lo = bus_we && (bus_addr == A_CNT_LO);
    assign cnt_wr_hi = bus_we && (bus_addr == A_CNT_HI);
    assign ctrl_wr   = bus_we && (bus_addr == A_CTRL);
    assign incr_wr   = bus_we && (bus_addr == A_INCR);
    assign pend_wr   = bus_we && (bus_addr == A_PEND);
    assign ien_wr    = bus_we && (bus_addr == A_IEN);
    assign gstat_wr  = bus_we && (bus_addr == A_GSTAT);
    assign cstat_wr  = bus_we && (bus_addr == A_CSTAT);

    for (genvar k = 0; k < NCMP; k++) begin : g_chan
        assign cmp_wr_lo[k] = bus_we && (bus_addr == cmp_lo_addr(k));
        assign cmp_wr_hi[k] = bus_we && (bus_addr == cmp_hi_addr(k));
        gct_cmp_chan #(.CW(CNT_W), .IW(HALF_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_i   (s_q.cnt),
            .run_i   (s_q.run),
            .en_i    (s_q.cmp_en[k]),
            .auto_i  ((k == 0) ? s_q.auto_inc : 1'b0),
            .incr_i  (s_q.incr),
            .wr_lo_i (cmp_wr_lo[k]),
            .wr_hi_i (cmp_wr_hi[k]),
            .wdata_i (bus_wdata),
            .cmp_o   (cmp_w[k]),
            .hit_o   (hit_w[k])
        );
    end

    // Confirmation request vectors
    always_comb begin
        gack = '0;
        for (int k = 0; k < NCMP; k++) begin
            gack[4*k]   = cmp_wr_lo[k];
            gack[4*k+1] = cmp_wr_hi[k];
        end
        gack[INC_ACK_BIT]  = incr_wr;
        gack[CTRL_ACK_BIT] = ctrl_wr;
        cack = {cnt_wr_hi, cnt_wr_lo};
    end

    gct_wack #(.W(HALF_W), .DEPTH(ACK_DELAY)) u_gack (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (gack),
        .clr_i  (gstat_wr ? bus_wdata : '0),
        .stat_o (gstat)
    );

    gct_wack #(.W(2), .DEPTH(ACK_DELAY)) u_cack (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (cack),
        .clr_i  (cstat_wr ? bus_wdata[1:0] : 2'b00),
        .stat_o (cstat)
    );

    // Next-state logic
    always_comb begin
        s_d = s_q;
        if (s_q.run) s_d.cnt = s_q.cnt + 1'b1;
        if (cnt_wr_lo) s_d.cnt[HALF_W-1:0]     = bus_wdata;
        if (cnt_wr_hi) s_d.cnt[CNT_W-1:HALF_W] = bus_wdata;
        if (ctrl_wr) begin
            s_d.run      = bus_wdata[RUN_BIT];
            s_d.auto_inc = bus_wdata[AUTO_BIT];
            for (int k = 0; k < NCMP; k++) s_d.cmp_en[k] = bus_wdata[2*k];
        end
        if (incr_wr) s_d.incr = bus_wdata;
        if (ien_wr)  s_d.ien  = bus_wdata[NCMP-1:0];
        if (pend_wr) s_d.pend = s_q.pend & ~bus_wdata[NCMP-1:0];
        s_d.pend = s_d.pend | hit_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.pend & s_q.ien;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_LO: bus_rdata = s_q.cnt[HALF_W-1:0];
            A_CNT_HI: bus_rdata = s_q.cnt[CNT_W-1:HALF_W];
            A_CSTAT:  bus_rdata = {{(HALF_W-2){1'b0}}, cstat};
            A_INCR:   bus_rdata = s_q.incr;
            A_CTRL: begin
                bus_rdata[RUN_BIT]  = s_q.run;
                bus_rdata[AUTO_BIT] = s_q.auto_inc;
                for (int k = 0; k < NCMP; k++) bus_rdata[2*k] = s_q.cmp_en[k];
            end
            A_PEND:   bus_rdata[NCMP-1:0] = s_q.pend;
            A_IEN:    bus_rdata[NCMP-1:0] = s_q.ien;
            A_GSTAT:  bus_rdata = gstat;
            default:  bus_rdata = '0;
        endcase
        for (int k = 0; k < NCMP; k++) begin
            if (bus_addr == cmp_lo_addr(k)) bus_rdata = cmp_w[k][HALF_W-1:0];
            if (bus_addr == cmp_hi_addr(k)) bus_rdata = cmp_w[k][CNT_W-1:HALF_W];
        end
    end
endmodule

// File: rtl/gct_chk.sv
`timescale 1ns/1ps
module gct_chk
    import gct_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              run_q,
    input logic              auto_q,
    input logic [HALF_W-1:0] incr_q,
    input logic [NCMP-1:0]   pend_q,
    input logic [HALF_W-1:0] gstat,
    input logic [CNT_W-1:0]  cmp0,
    input logic              hit0,
    input logic              cmp0_wr
);
    logic cnt_wr;
    assign cnt_wr = bus_we && ((bus_addr == A_CNT_LO) || (bus_addr == A_CNT_HI));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && !cnt_wr |=> cnt_q == $past(cnt_q) + 1'b1);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !cnt_wr |=> $stable(cnt_q));

    // R11
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(gstat) & ~gstat)) |-> $past(bus_we && (bus_addr == A_GSTAT)));

    // R4
    pend0_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[0]) |-> $past(cnt_q == cmp0));

    // R7
    auto_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_q && hit0 && !cmp0_wr |=> cmp0 == $past(cmp0 + CNT_W'(incr_q)));
endmodule

bind gcmp_timer gct_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .cnt_q    (s_q.cnt),
    .run_q    (s_q.run),
    .auto_q   (s_q.auto_inc),
    .incr_q   (s_q.incr),
    .pend_q   (s_q.pend),
    .gstat    (gstat),
    .cmp0     (cmp_w[0]),
    .hit0     (hit_w[0]),
    .cmp0_wr  (cmp_wr_lo[0] || cmp_wr_hi[0])
);

// File: tb/gcmp_timer_tb_top.sv
`timescale 1ns/1ps
module gcmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    typedef struct {
        bit          is_irq;
        logic [11:0] addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    gcmp_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Monitor: compares each queued item a little after the falling edge
    always @(negedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {28'b0, irq} : bus_rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h",
                         it.req, it.addr, act, it.exp);
            end
        end
    end

    // Driver tasks, called at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string r);
        bus_addr = a;
        sb_q.push_back('{1'b0, a, e, r});
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic [3:0] e, input string r);
        sb_q.push_back('{1'b1, 12'h000, {28'b0, e}, r});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL all-reqs watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h100, 32'h0, "R1 cnt lo");
        rd(12'h104, 32'h0, "R1 cnt hi");
        rd(12'h240, 32'h0, "R1 ctrl");
        rd(12'h244, 32'h0, "R1 pending");
        rd(12'h24C, 32'h0, "R1 gstat");
        rd(12'h110, 32'h0, "R1 cstat");
        chk_irq(4'h0, "R1 irq");

        // R2 load halves while stopped
        wr(12'h100, 32'hFFFF_FFFE);
        wr(12'h104, 32'h0000_0001);
        rd(12'h100, 32'hFFFF_FFFE, "R2 cnt lo");
        rd(12'h104, 32'h0000_0001, "R2 cnt hi");

        // R3 run three edges, carry across halves, then hold
        wr(12'h240, 32'h100);
        idle(2);
        wr(12'h240, 32'h0);
        rd(12'h100, 32'h1, "R3 cnt lo after carry");
        rd(12'h104, 32'h2, "R3 cnt hi after carry");
        idle(3);
        rd(12'h100, 32'h1, "R3 cnt holds when stopped");

        // R4 R6 compare channels 1..3 at value 10
        wr(12'h100, 32'h0);
        wr(12'h104, 32'h0);
        wr(12'h210, 32'd10); wr(12'h214, 32'h0);
        wr(12'h220, 32'd10); wr(12'h224, 32'h0);
        wr(12'h230, 32'd10); wr(12'h234, 32'h0);
        wr(12'h248, 32'h7);
        wr(12'h240, 32'h144);
        idle(20);
        wr(12'h240, 32'h0);
        rd(12'h244, 32'hA, "R4 pending only for enabled channels 1,3");
        chk_irq(4'h2, "R6 irq masked on channel 3");

        // R5 clear pending 1
        wr(12'h244, 32'h2);
        rd(12'h244, 32'h8, "R5 pending after W1C");
        chk_irq(4'h0, "R5 irq drops after clear");

        // R7 periodic channel 0
        wr(12'h100, 32'h0);
        wr(12'h200, 32'd20);
        wr(12'h204, 32'h0);
        wr(12'h208, 32'd5);
        wr(12'h248, 32'h1);
        wr(12'h240, 32'h103);
        idle(30);
        wr(12'h240, 32'h0);
        rd(12'h100, 32'd31, "R7 counter at stop");
        rd(12'h200, 32'd35, "R7 compare0 re-armed");
        rd(12'h204, 32'h0,  "R7 compare0 hi");
        rd(12'h208, 32'd5,  "R7 increment readback");
        rd(12'h244, 32'h9,  "R7 pending0 set");
        rd(12'h210, 32'd10, "R7 one-shot channel keeps value");
        chk_irq(4'h1, "R7 irq0");

        // Clear confirmation registers
        idle(4);
        wr(12'h24C, 32'hFFFF_FFFF);
        wr(12'h110, 32'h3);
        rd(12'h24C, 32'h0, "R11 gstat cleared");
        rd(12'h110, 32'h0, "R11 cstat cleared");

        // R8 exact confirmation latency
        wr(12'h200, 32'd7);
        rd(12'h24C, 32'h0, "R8 not after first edge");
        rd(12'h24C, 32'h0, "R8 not after second edge");
        rd(12'h24C, 32'h1, "R8 set after write plus two");

        // R9 R10 bit map
        wr(12'h104, 32'd5);
        wr(12'h208, 32'd9);
        wr(12'h240, 32'h0);
        wr(12'h234, 32'h0);
        idle(3);
        rd(12'h110, 32'h2, "R9 counter hi confirm");
        rd(12'h24C, 32'h0001_2005, "R10 cmp0 lo, incr, cmp3 hi, ctrl bits");
        rd(12'h104, 32'd5, "R2 cnt hi reload");

        // R11 partial clear
        wr(12'h24C, 32'h0000_2004);
        rd(12'h24C, 32'h0001_0001, "R11 zeros leave bits set");

        idle(4);
        done = 1;
        summary();
        $finish;
    end
endmodule